// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block keeps wall-clock time as a 32-bit count of seconds. A divider, programmed with the reference clock rate in Hz, turns the reference clock into a once-per-second step. Software reaches the block through a bank of 16-bit registers on a single-cycle read/write port. Every 32-bit quantity is split into a low half and a high half.

Software sets the time by writing a start value and then raising a load request bit. It reads the time by raising a capture request bit and then reading a frozen copy of the count. Hardware drops each request bit once it has been served, so software can poll for completion. A compare register raises an alarm when the count reaches it. The single interrupt line can be masked, forced on for test, and acknowledged. All logic runs on one clock.

Register word offsets are fixed: control 0x00, divider low/high 0x04/0x08, start value low/high 0x0C/0x10, compare low/high 0x14/0x18, status 0x1C, captured count low/high 0x20/0x24. Control bits are: 0 live (0 = soft reset), 1 count enable, 2 wrap enable, 3 load request, 4 capture request, 5 interrupt mask, 6 interrupt force, 7 interrupt acknowledge. Status bits are: 0 raw interrupt, 1 alarm pending. The port has no valid/ready handshake. A write takes effect at the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The divider, start value and compare halves read back what was written. Writes to status and captured-count offsets change nothing.
- R3: With live and count enable set, the count rises by one every D clock cycles, where D is the divider value. A divider of 0 behaves as 1. With count enable at 0 the count does not move.
- R4: Setting load request (bit 3) copies the start value into the count at the next edge, and the bit then reads 0. A load beats a step in the same cycle and restarts the divider.
- R5: Setting capture request (bit 4) freezes the current count into the captured-count registers at the next edge, and the bit then reads 0. The captured value stays put while the count keeps running.
- R6: At count 0xFFFFFFFF a step gives 0 when wrap enable (bit 2) is 1, and leaves 0xFFFFFFFF otherwise.
- R7: Status bit 1 (alarm pending) sets when the count takes the compare value, whether by a step or by a load.
- R8: While the mask bit (bit 5) is 1, `irq` stays 0 and the status bits keep their values.
- R9: Writing control with bit 7 set clears a pending alarm, and bit 7 always reads 0.
- R10: While force (bit 6) is 1, status bit 0 and an unmasked `irq` are 1 with no alarm pending.
- R11: While live (bit 0) is 0, the divider state, count, captured count and pending alarm are cleared. The programmed registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, the only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register; bits 1:0 must be 0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt, high while raw interrupt is set and not masked |

## Verification
The count path is tried with start values spread over the whole range and bunched just below the top, divider values from 0 to 5, wait lengths from zero cycles upward, and the enable and wrap bits drawn at random. These draws separate a wrong step rate, a missed hold, a missed wrap and a lost load. A zero-cycle wait, with capture requested on the load edge, shows whether a load beats a step. The interrupt path is taken through step-driven and load-driven matches, masking, acknowledge, force, and a soft reset with an alarm pending. These runs show whether the pending state, the raw bit and the output gate are kept apart.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  // Word indexes (byte offset / 4); software decodes these, so they are fixed.
  localparam int RA_CTRL    = 0;
  localparam int RA_DIV_LO  = 1;
  localparam int RA_DIV_HI  = 2;
  localparam int RA_LD_LO   = 3;
  localparam int RA_LD_HI   = 4;
  localparam int RA_MT_LO   = 5;
  localparam int RA_MT_HI   = 6;
  localparam int RA_STAT    = 7;
  localparam int RA_SNAP_LO = 8;
  localparam int RA_SNAP_HI = 9;

  localparam int CB_ACK = 7;

  // Stored control bits, packed so that bit n of the struct is control bit n.
  typedef struct packed {
    logic force_irq;  // 6
    logic mask;       // 5
    logic snap;       // 4
    logic load;       // 3
    logic wrap;       // 2
    logic en;         // 1
    logic live;       // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
  import sec_rtc_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  input  logic                  stat_raw,
  input  logic                  stat_pend,
  input  logic [2*REG_W-1:0]    snap_val,
  output ctrl_t                 ctrl,
  output logic [2*REG_W-1:0]    div_word,
  output logic [2*REG_W-1:0]    load_word,
  output logic [2*REG_W-1:0]    match_word,
  output logic                  ack_pulse
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr_ok;
  logic             wr_ctrl;
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] div_lo, div_hi, ld_lo, ld_hi, mt_lo, mt_hi;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && aligned;
  assign wr_ctrl = wr_ok && (idx == IDX_W'(RA_CTRL));

  assign ack_pulse = wr_ctrl && bus_wdata[CB_ACK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_lo <= '0; div_hi <= '0;
      ld_lo  <= '0; ld_hi  <= '0;
      mt_lo  <= '0; mt_hi  <= '0;
    end else begin
      // Request bits are served in the cycle after they are seen.
      if (ctrl_q.load) ctrl_q.load <= 1'b0;
      if (ctrl_q.snap) ctrl_q.snap <= 1'b0;
      if (wr_ok) begin
        case (idx)
          IDX_W'(RA_CTRL):   ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
          IDX_W'(RA_DIV_LO): div_lo <= bus_wdata;
          IDX_W'(RA_DIV_HI): div_hi <= bus_wdata;
          IDX_W'(RA_LD_LO):  ld_lo  <= bus_wdata;
          IDX_W'(RA_LD_HI):  ld_hi  <= bus_wdata;
          IDX_W'(RA_MT_LO):  mt_lo  <= bus_wdata;
          IDX_W'(RA_MT_HI):  mt_hi  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  assign ctrl       = ctrl_q;
  assign div_word   = {div_hi, div_lo};
  assign load_word  = {ld_hi, ld_lo};
  assign match_word = {mt_hi, mt_lo};

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(RA_CTRL):    bus_rdata = REG_W'(ctrl_q);
        IDX_W'(RA_DIV_LO):  bus_rdata = div_lo;
        IDX_W'(RA_DIV_HI):  bus_rdata = div_hi;
        IDX_W'(RA_LD_LO):   bus_rdata = ld_lo;
        IDX_W'(RA_LD_HI):   bus_rdata = ld_hi;
        IDX_W'(RA_MT_LO):   bus_rdata = mt_lo;
        IDX_W'(RA_MT_HI):   bus_rdata = mt_hi;
        IDX_W'(RA_STAT):    bus_rdata = REG_W'({stat_pend, stat_raw});
        IDX_W'(RA_SNAP_LO): bus_rdata = snap_val[REG_W-1:0];
        IDX_W'(RA_SNAP_HI): bus_rdata = snap_val[2*REG_W-1:REG_W];
        default:            bus_rdata = '0;
      endcase
    end
  end

  AST_LOAD_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.load && !wr_ctrl |=> !ctrl_q.load); // R4
  AST_SNAP_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.snap && !wr_ctrl |=> !ctrl_q.snap); // R5

endmodule

// File: rtl/sec_rtc_presc.sv
module sec_rtc_presc #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);

  logic [CNT_W-1:0] pre;
  logic [CNT_W-1:0] limit;
  logic             hold;

  // A divider of 0 behaves as 1: a step on every enabled cycle.
  assign limit = (div == '0) ? '0 : div - CNT_W'(1);
  assign hold  = !live || !en || restart;
  assign tick  = !hold && (pre >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre <= '0;
    else if (hold)          pre <= '0;
    else if (pre >= limit)  pre <= '0;
    else                    pre <= pre + CNT_W'(1);
  end

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre == '0)); // R3

endmodule

// File: rtl/sec_rtc_count.sv
module sec_rtc_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live,
  input  logic             wrap,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             snap,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap_q,
  output logic             hit
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic             upd;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    upd = 1'b0;
    nxt = cnt;
    if (load) begin
      upd = 1'b1;
      nxt = load_val;
    end else if (tick) begin
      if (cnt != TOP) begin
        upd = 1'b1;
        nxt = cnt + CNT_W'(1);
      end else if (wrap) begin
        upd = 1'b1;
        nxt = '0;
      end
    end
  end

  // The alarm fires on the edge where the count takes the compare value.
  assign hit = live && upd && (nxt == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      snap_q <= '0;
    end else if (!live) begin
      cnt    <= '0;
      snap_q <= '0;
    end else begin
      if (upd)  cnt    <= nxt;
      if (snap) snap_q <= cnt;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    live && load |=> (cnt == $past(load_val))); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    live && !load && tick && (cnt != TOP) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3
  AST_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    live && !load && !wrap && (cnt == TOP) |=> (cnt == TOP)); // R6
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    live && snap |=> (snap_q == $past(cnt))); // R5
  AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (cnt == '0) && (snap_q == '0)); // R11

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic hit,
  input  logic ack,
  input  logic mask,
  input  logic force_irq,
  output logic pend,
  output logic raw,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= 1'b0;
    else if (!live) pend <= 1'b0;
    else if (hit)   pend <= 1'b1;
    else if (ack)   pend <= 1'b0;
  end

  assign raw = pend || force_irq;
  assign irq = raw && !mask;

  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    live && hit |=> pend); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    live && ack && !hit |=> !pend); // R9
  AST_SOFT_NOPEND: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !pend); // R11

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int CNT_W = 2 * REG_W;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] div_word, load_word, match_word;
  logic [CNT_W-1:0] cnt, snap_q;
  logic             ack_pulse, tick, hit, pend, raw;

  sec_rtc_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .stat_raw   (raw),
    .stat_pend  (pend),
    .snap_val   (snap_q),
    .ctrl       (ctrl),
    .div_word   (div_word),
    .load_word  (load_word),
    .match_word (match_word),
    .ack_pulse  (ack_pulse)
  );

  sec_rtc_presc #(.CNT_W(CNT_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .live    (ctrl.live),
    .en      (ctrl.en),
    .restart (ctrl.load),
    .div     (div_word),
    .tick    (tick)
  );

  sec_rtc_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (ctrl.live),
    .wrap      (ctrl.wrap),
    .load      (ctrl.load),
    .load_val  (load_word),
    .tick      (tick),
    .snap      (ctrl.snap),
    .match_val (match_word),
    .cnt       (cnt),
    .snap_q    (snap_q),
    .hit       (hit)
  );

  sec_rtc_alarm u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (ctrl.live),
    .hit       (hit),
    .ack       (ack_pulse),
    .mask      (ctrl.mask),
    .force_irq (ctrl.force_irq),
    .pend      (pend),
    .raw       (raw),
    .irq       (irq)
  );

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == '0 && bus_wdata[5]) |-> !irq); // R8

endmodule

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;

  localparam int REG_W = 16;
  localparam int ADDR_W = 6;

  localparam logic [5:0] A_CTRL = 6'h00, A_DLO = 6'h04, A_DHI = 6'h08,
                         A_LLO = 6'h0C, A_LHI = 6'h10, A_MLO = 6'h14,
                         A_MHI = 6'h18, A_ST = 6'h1C, A_SLO = 6'h20, A_SHI = 6'h24;
  localparam logic [15:0] B_LIVE = 16'h01, B_EN = 16'h02, B_WRAP = 16'h04,
                          B_LOAD = 16'h08, B_SNAP = 16'h10, B_MASK = 16'h20,
                          B_FORCE = 16'h40, B_ACK = 16'h80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [REG_W-1:0]  bus_wdata = '0;
  logic [REG_W-1:0]  bus_rdata;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;

  sec_rtc #(.REG_W(REG_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung act=%0d exp=0", 150000);
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd32(logic [5:0] a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd(a, lo);
    rd(a + 6'h04, hi);
    d = {hi, lo};
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_cnt(logic [31:0] l, int unsigned m,
                                          logic [31:0] d, bit en, bit wrap);
    logic [63:0] s;
    int unsigned dd;
    if (!en) return l;
    dd = (d == 0) ? 1 : int'(d);
    s = {32'b0, l} + 64'(m / dd);
    if (s > 64'h0000_0000_FFFF_FFFF) return wrap ? s[31:0] : 32'hFFFF_FFFF;
    return s[31:0];
  endfunction

  // Load l, wait m cycles, capture, and compare with the computed count.
  task automatic run_case(logic [31:0] l, logic [31:0] d, int unsigned m,
                          bit en, bit wrap, string tag);
    logic [15:0] base, r;
    logic [31:0] s1, s2, e;
    base = B_LIVE | B_MASK | (en ? B_EN : 16'h0) | (wrap ? B_WRAP : 16'h0);
    wr(A_DLO, d[15:0]); wr(A_DHI, d[31:16]);
    wr(A_LLO, l[15:0]); wr(A_LHI, l[31:16]);
    wr(A_CTRL, base);
    wr(A_CTRL, base | B_LOAD);
    rd(A_CTRL, r);
    chk("R4 load bit visible", 32'(r & B_LOAD), 32'(B_LOAD));
    if (m > 0) begin
      idle(1);
      rd(A_CTRL, r);
      chk("R4 load bit self-clears", 32'(r & B_LOAD), 32'h0);
      idle(m - 1);
    end
    wr(A_CTRL, base | B_SNAP);
    idle(1);
    rd(A_CTRL, r);
    chk("R5 capture bit self-clears", 32'(r & B_SNAP), 32'h0);
    rd32(A_SLO, s1);
    e = exp_cnt(l, m, d, en, wrap);
    chk(tag, s1, e);
    if (en) begin
      idle(3);
      rd32(A_SLO, s2);
      chk("R5 capture stable", s2, s1);
    end
  endtask

  initial begin
    logic [15:0] r;
    logic [31:0] v;
    int seed;
    logic [31:0] last_d;
    seed = int'($urandom(32'h5EED));
    last_d = 0;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), r);
      chk("R1 register zero after reset", 32'(r), 32'h0);
    end
    chk("R1 irq low after reset", 32'(irq), 32'h0);

    // R2: readback and read-only offsets
    wr(A_DLO, 16'h1234); wr(A_DHI, 16'hABCD);
    rd32(A_DLO, v);
    chk("R2 divider readback", v, 32'hABCD_1234);
    wr(A_MLO, 16'h5A5A); wr(A_MHI, 16'hC3C3);
    rd32(A_MLO, v);
    chk("R2 compare readback", v, 32'hC3C3_5A5A);
    wr(A_ST, 16'hFFFF); wr(A_SLO, 16'hBEEF); wr(A_SHI, 16'hF00D);
    rd(A_ST, r);   chk("R2 status write ignored", 32'(r), 32'h0);
    rd32(A_SLO, v); chk("R2 capture write ignored", v, 32'h0);

    // R7/R8/R9: alarm by stepping
    wr(A_DLO, 16'd1); wr(A_DHI, 16'd0);
    wr(A_LLO, 16'd100); wr(A_LHI, 16'd0);
    wr(A_MLO, 16'd103); wr(A_MHI, 16'd0);
    wr(A_CTRL, B_LIVE | B_EN);
    wr(A_CTRL, B_LIVE | B_EN | B_LOAD);
    idle(2);
    rd(A_ST, r);  chk("R7 no alarm before match", 32'(r), 32'h0);
    chk("R7 irq low before match", 32'(irq), 32'h0);
    idle(6);
    rd(A_ST, r);  chk("R7 alarm pending after match", 32'(r), 32'h3);
    chk("R7 irq high after match", 32'(irq), 32'h1);
    wr(A_CTRL, B_LIVE | B_EN | B_MASK);
    chk("R8 mask holds irq low", 32'(irq), 32'h0);
    rd(A_ST, r);  chk("R8 status kept while masked", 32'(r), 32'h3);
    wr(A_CTRL, B_LIVE | B_EN | B_MASK | B_ACK);
    rd(A_ST, r);  chk("R9 acknowledge clears alarm", 32'(r), 32'h0);
    rd(A_CTRL, r); chk("R9 ack bit reads 0", 32'(r), 32'(B_LIVE | B_EN | B_MASK));

    // R10: force
    wr(A_CTRL, B_LIVE | B_EN | B_FORCE);
    rd(A_ST, r);  chk("R10 force sets raw only", 32'(r), 32'h1);
    chk("R10 force drives irq", 32'(irq), 32'h1);
    wr(A_CTRL, B_LIVE | B_EN);
    rd(A_ST, r);  chk("R10 force released", 32'(r), 32'h0);
    chk("R10 irq drops with force", 32'(irq), 32'h0);

    // Directed count cases
    run_case(32'd500, 32'd1, 0, 1'b1, 1'b0, "R4 load beats step");
    run_case(32'd1000, 32'd0, 5, 1'b1, 1'b0, "R3 divider 0 acts as 1");
    run_case(32'h1234_5678, 32'd3, 10, 1'b1, 1'b0, "R3 divide by 3");
    run_case(32'd7777, 32'd2, 9, 1'b0, 1'b0, "R3 disabled count frozen");
    run_case(32'hFFFF_FFFE, 32'd1, 5, 1'b1, 1'b1, "R6 wrap to zero");
    run_case(32'hFFFF_FFFE, 32'd1, 5, 1'b1, 1'b0, "R6 hold at top");

    // Constrained random count cases
    for (int i = 0; i < 24; i++) begin
      logic [31:0] l, d;
      int unsigned m;
      bit en, wrap;
      l = $urandom;
      if (i % 3 == 0) l = 32'hFFFF_FFFF - ($urandom % 8);
      d = $urandom % 6;
      m = $urandom % 20;
      en = ($urandom % 4) != 0;
      wrap = $urandom % 2;
      last_d = d;
      run_case(l, d, m, en, wrap, "R3 R6 random count");
    end

    // R7 by load, then R11 soft reset clears it
    wr(A_MLO, 16'h4242); wr(A_MHI, 16'h0);
    wr(A_LLO, 16'h4242); wr(A_LHI, 16'h0);
    wr(A_CTRL, B_LIVE | B_MASK);
    wr(A_CTRL, B_LIVE | B_MASK | B_LOAD);
    idle(1);
    rd(A_ST, r);  chk("R7 alarm on load match", 32'(r & 16'h2), 32'h2);
    wr(A_CTRL, B_LIVE | B_EN | B_MASK | B_SNAP);
    idle(1);
    wr(A_CTRL, B_MASK);
    idle(1);
    rd(A_ST, r);   chk("R11 alarm cleared in soft reset", 32'(r), 32'h0);
    rd32(A_SLO, v); chk("R11 capture cleared in soft reset", v, 32'h0);
    rd32(A_DLO, v); chk("R11 divider kept", v, last_d);
    rd32(A_LLO, v); chk("R11 start value kept", v, 32'h0000_4242);
    rd(A_CTRL, r);  chk("R11 control kept", 32'(r), 32'(B_MASK));

    summary();
    $finish;
  end

endmodule